// File: doc/BRIEF.md
# Branch-Folding Fetch and Recovery Unit

This unit forms the front end of a short in-order pipeline: it fetches pairs of 16-bit instruction words and builds one decoded entry per cycle. A branch that directly follows a non-branch instruction is merged into that instruction's entry, so it never uses an execution slot of its own. Each entry names the address to fetch next. A conditional entry whose outcome is still unknown also carries the address of the path it did not take.

After decode, an entry moves through issue, execute and writeback stages. The path of an unresolved conditional branch is chosen from a static prediction bit in the branch word. When no compare is in flight in issue or execute, the condition flag is already final, so the branch takes its real direction and can never be wrong. A predicted branch is resolved in execute. On a wrong guess, the younger work in issue and decode is discarded and the carried address becomes the next fetch address.

Compares get their result from an outside execution unit. The unit raises a request with the compare's address and takes the one-bit result in the same cycle.

Top module: `bf_fetch_unit`

## Requirements
- R1: While reset is held, fetch_addr_o is 0, wb_valid_o is 0, flush_o is 0 and flag_o is 0.
- R2: Word layout: bits [15:14] give the class (0 ALU, 1 compare, 2 jump, 3 conditional jump). Bit 12 set predicts taken. Bits [11:0] are the absolute target. A non-branch word whose successor is not a branch retires alone, and fetch continues at its address plus one.
- R3: A non-branch word at A followed by a branch at A+1 forms one entry. Only A retires, and the branch never shows up at writeback. The fall-through address of that entry is A+2.
- R4: A branch word at the fetch address, including a conditional jump reached directly from another branch, is not merged. It forms its own entry and retires with its own class and address.
- R5: A conditional entry decoded while a compare is in issue or execute, or whose own merged word is a compare, fetches next along the path selected by bit 12.
- R6: A conditional entry decoded with no compare in issue or execute follows the flag at once and never causes a flush.
- R7: A wrong prediction raises flush_o in the cycle the entry is in execute. Nothing younger retires, and the next fetch_addr_o is the entry's carried alternate address.
- R8: Only a compare changes the flag. The compare is presented on cmp_req_o and cmp_addr_o while it is in execute, and the flag takes cmp_result_i at the end of that cycle.
- R9: Entries retire at writeback in the architectural program order.
- R10: A conditional jump is taken exactly when the flag is 1. An entry that merges a compare uses that compare's own result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_word0_i | input | 16 | Instruction word at fetch_addr_o |
| fetch_word1_i | input | 16 | Instruction word at fetch_addr_o + 1 |
| cmp_result_i | input | 1 | Result of the compare currently requested |
| fetch_addr_o | output | 12 | Current fetch address |
| cmp_req_o | output | 1 | A compare is in execute |
| cmp_addr_o | output | 12 | Address of that compare |
| flush_o | output | 1 | Misprediction found in execute this cycle |
| flag_o | output | 1 | Condition flag |
| wb_valid_o | output | 1 | An entry retires this cycle |
| wb_addr_o | output | 12 | Address of the retiring entry's leading word |
| wb_cls_o | output | 2 | Class of that leading word |

## Verification
The hardest case to reach is the choice between the bypass and the prediction. It depends on whether a compare happens to sit in issue or execute in the exact cycle a conditional jump is decoded, which the ports show only indirectly. Directed programs place a compare either two cycles ahead of a merged conditional or far enough back that it has already retired. The bench then samples fetch_addr_o in the cycle after that decode. Seeded random programs full of compares and branches repeat this timing many times, and every retirement is compared with an architectural walk of the same program.

// File: rtl/bf_pkg.sv
package bf_pkg;
    localparam int ADDR_W   = 12;
    localparam int WORD_W   = 16;
    localparam int CLS_HI   = 15;
    localparam int CLS_LO   = 14;
    localparam int PRED_BIT = 12;

    typedef enum logic [1:0] {
        CLS_ALU  = 2'd0,
        CLS_CMP  = 2'd1,
        CLS_JMP  = 2'd2,
        CLS_CJMP = 2'd3
    } cls_e;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef struct packed {
        logic  valid;
        addr_t addr;     // address of the leading word
        cls_e  cls;      // class of the leading word
        logic  has_cmp;  // entry performs a compare
        logic  pending;  // conditional outcome still to be resolved
        logic  guess;    // direction chosen at decode
        addr_t alt;      // path not taken
    } slot_t;
endpackage

// File: rtl/bf_fold_decoder.sv
module bf_fold_decoder
    import bf_pkg::*;
(
    input  addr_t              pc_i,
    input  logic [WORD_W-1:0]  w0_i,
    input  logic [WORD_W-1:0]  w1_i,
    input  logic               guess_en_i,
    input  logic               flag_i,
    output slot_t              slot_o,
    output addr_t              next_o
);
    logic [1:0]        c0, c1, cb;
    logic              lone, fold;
    logic [WORD_W-1:0] bw;
    addr_t             fall, tgt;

    always_comb begin
        c0   = w0_i[CLS_HI:CLS_LO];
        c1   = w1_i[CLS_HI:CLS_LO];
        lone = c0[1];
        fold = !c0[1] && c1[1];
        bw   = lone ? w0_i : w1_i;
        cb   = bw[CLS_HI:CLS_LO];
        fall = lone ? pc_i + ADDR_W'(1) : pc_i + ADDR_W'(2);
        tgt  = bw[ADDR_W-1:0];

        slot_o         = '0;
        slot_o.valid   = 1'b1;
        slot_o.addr    = pc_i;
        slot_o.cls     = cls_e'(c0);
        slot_o.has_cmp = (c0 == CLS_CMP);
        next_o         = pc_i + ADDR_W'(1);

        if (lone || fold) begin
            if (cb == CLS_JMP) begin
                next_o = tgt;
            end else if (guess_en_i || slot_o.has_cmp) begin
                slot_o.pending = 1'b1;
                slot_o.guess   = bw[PRED_BIT];
                next_o         = bw[PRED_BIT] ? tgt : fall;
                slot_o.alt     = bw[PRED_BIT] ? fall : tgt;
            end else begin
                next_o = flag_i ? tgt : fall;
            end
        end
    end
endmodule

// File: rtl/bf_resolver.sv
module bf_resolver
    import bf_pkg::*;
(
    input  slot_t ex_i,
    input  logic  cmp_res_i,
    input  logic  flag_q_i,
    output logic  miss_o,
    output logic  flag_d_o
);
    logic outcome;

    always_comb begin
        outcome  = ex_i.has_cmp ? cmp_res_i : flag_q_i;
        miss_o   = ex_i.valid && ex_i.pending && (outcome != ex_i.guess);
        flag_d_o = (ex_i.valid && ex_i.has_cmp) ? cmp_res_i : flag_q_i;
    end
endmodule

// File: rtl/bf_fetch_unit.sv
module bf_fetch_unit
    import bf_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] fetch_word0_i,
    input  logic [WORD_W-1:0] fetch_word1_i,
    input  logic              cmp_result_i,
    output logic [ADDR_W-1:0] fetch_addr_o,
    output logic              cmp_req_o,
    output logic [ADDR_W-1:0] cmp_addr_o,
    output logic              flush_o,
    output logic              flag_o,
    output logic              wb_valid_o,
    output logic [ADDR_W-1:0] wb_addr_o,
    output logic [1:0]        wb_cls_o
);
    typedef struct packed {
        addr_t            pc;
        slot_t            iss;
        slot_t            exe;
        slot_t            wbk;
        logic             flag;
        logic [CNT_W-1:0] cnt;
    } state_t;

    state_t q, d;
    slot_t  dec_slot;
    addr_t  dec_next;
    logic   miss, flag_d;

    bf_fold_decoder u_dec (
        .pc_i       (q.pc),
        .w0_i       (fetch_word0_i),
        .w1_i       (fetch_word1_i),
        .guess_en_i (q.cnt != '0),
        .flag_i     (q.flag),
        .slot_o     (dec_slot),
        .next_o     (dec_next)
    );

    bf_resolver u_res (
        .ex_i      (q.exe),
        .cmp_res_i (cmp_result_i),
        .flag_q_i  (q.flag),
        .miss_o    (miss),
        .flag_d_o  (flag_d)
    );

    always_comb begin
        d      = q;
        d.pc   = miss ? q.exe.alt : dec_next;
        d.iss  = miss ? '0 : dec_slot;
        d.exe  = miss ? '0 : q.iss;
        d.wbk  = q.exe;
        d.flag = flag_d;
        d.cnt  = q.cnt
               + CNT_W'(d.iss.valid && d.iss.has_cmp)
               - CNT_W'(q.exe.valid && q.exe.has_cmp)
               - CNT_W'(miss && q.iss.valid && q.iss.has_cmp);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign fetch_addr_o = q.pc;
    assign cmp_req_o    = q.exe.valid && q.exe.has_cmp;
    assign cmp_addr_o   = q.exe.addr;
    assign flush_o      = miss;
    assign flag_o       = q.flag;
    assign wb_valid_o   = q.wbk.valid;
    assign wb_addr_o    = q.wbk.addr;
    assign wb_cls_o     = q.wbk.cls;

    // R7: redirect goes to the carried address on the following cycle
    p_redirect_alt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |=> fetch_addr_o == $past(q.exe.alt));
    // R7: the younger issue entry never reaches execute
    p_flush_kills_issue_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |=> !q.exe.valid);
    // R6: in-flight compare counter matches the stage contents
    p_cnt_tracks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt == CNT_W'(q.iss.valid && q.iss.has_cmp) + CNT_W'(q.exe.valid && q.exe.has_cmp));
    // R8: flag changes only behind a compare in execute
    p_flag_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(q.exe.valid && q.exe.has_cmp) |=> $stable(q.flag));
    // R9: writeback is fed only from execute
    p_wb_after_ex_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid_o |-> $past(q.exe.valid));
endmodule

// File: tb/bf_fetch_unit_bench.sv
module bf_fetch_unit_bench;
    localparam int PERIOD = 10;

    logic        clk = 0, rst_n = 0;
    logic [15:0] mem [64];
    logic        tab [64];
    logic [15:0] w0, w1;
    logic        cmp_result, cmp_req, flush, flag, wb_valid;
    logic [11:0] fetch_addr, cmp_addr, wb_addr;
    logic [1:0]  wb_cls;
    int          total = 0, fails = 0;
    logic [11:0] gpc;
    logic        gflag;

    always #(PERIOD/2) clk = ~clk;

    assign w0 = mem[fetch_addr[5:0]];
    assign w1 = mem[fetch_addr[5:0] + 6'd1];
    assign cmp_result = cmp_req & tab[cmp_addr[5:0]];

    bf_fetch_unit u_bf_fetch_unit (
        .clk(clk), .rst_n(rst_n), .fetch_word0_i(w0), .fetch_word1_i(w1),
        .cmp_result_i(cmp_result), .fetch_addr_o(fetch_addr), .cmp_req_o(cmp_req),
        .cmp_addr_o(cmp_addr), .flush_o(flush), .flag_o(flag), .wb_valid_o(wb_valid),
        .wb_addr_o(wb_addr), .wb_cls_o(wb_cls));

    function automatic logic [15:0] enc(input logic [1:0] c, input logic p, input logic [11:0] t);
        return {c, 1'b0, p, t};
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // architectural walk: one retiring entry per call
    task automatic gold_next(output logic [11:0] a, output logic [1:0] c, output string tag);
        logic [15:0] x0, x1;
        x0 = mem[gpc[5:0]];
        x1 = mem[gpc[5:0] + 6'd1];
        a = gpc;
        c = x0[15:14];
        if (x0[15]) begin
            tag = "R4";
            if (x0[14] == 1'b0 || gflag) gpc = x0[11:0];   // R10
            else gpc = gpc + 12'd1;
        end else begin
            if (c == 2'd1) gflag = tab[gpc[5:0]];
            if (x1[15]) begin
                tag = "R3";
                if (x1[14] == 1'b0 || gflag) gpc = x1[11:0];
                else gpc = gpc + 12'd2;
            end else begin
                tag = (c == 2'd1) ? "R8" : "R2";
                gpc = gpc + 12'd1;
            end
        end
    endtask

    task automatic run_prog(input int ncyc, input int probe_cyc, input logic [11:0] probe_addr,
                            input string probe_tag, input int flush_cyc, input bit no_flush);
        logic [11:0] ea;
        logic [1:0]  ec;
        string       et;
        int          nfl;
        nfl = 0; gpc = 0; gflag = 0;
        rst_n = 0;
        @(negedge clk); @(negedge clk);
        chk(fetch_addr == 0 && !wb_valid && !flush && !flag, "R1 reset", fetch_addr, 0);
        rst_n = 1;
        for (int i = 1; i <= ncyc; i++) begin
            @(negedge clk);
            if (wb_valid) begin
                gold_next(ea, ec, et);
                chk(wb_addr == ea && wb_cls == ec, {et, " R9 retire"}, {wb_cls, wb_addr}, {ec, ea});
                if (ec == 2'd1) chk(flag == tab[ea[5:0]], "R8 flag", flag, tab[ea[5:0]]);
            end
            if (flush) nfl++;
            if (i == probe_cyc) chk(fetch_addr == probe_addr, probe_tag, fetch_addr, probe_addr);
            if (i == flush_cyc) chk(flush == 1'b1, "R7 flush", flush, 1);
        end
        if (no_flush) chk(nfl == 0, "R6 no flush", nfl, 0);
    endtask

    task automatic clear_prog();
        for (int k = 0; k < 64; k++) begin mem[k] = 16'h0; tab[k] = 1'b0; end
    endtask

    initial begin
        #(PERIOD * 150000);
        fails++; total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_b00f));
        // R7: merged compare+conditional predicted not taken, compare says taken
        clear_prog();
        mem[0] = enc(2'd1, 1'b0, 12'd0);
        mem[1] = enc(2'd3, 1'b0, 12'd10);
        tab[0] = 1'b1;
        run_prog(20, 3, 12'd10, "R7 redirect", 2, 1'b0);
        // R5: compare in execute while a merged conditional decodes, predicted taken
        clear_prog();
        mem[0] = enc(2'd1, 1'b0, 12'd0);
        mem[3] = enc(2'd3, 1'b1, 12'd20);
        tab[0] = 1'b1;
        run_prog(20, 3, 12'd20, "R5 predicted path", -1, 1'b1);
        // R6/R10: compare long retired, bypass follows flag=1, taken, no flush
        clear_prog();
        mem[0]  = enc(2'd2, 1'b0, 12'd5);
        mem[5]  = enc(2'd3, 1'b1, 12'd9);
        mem[6]  = enc(2'd1, 1'b0, 12'd0);
        mem[11] = enc(2'd3, 1'b0, 12'd30);
        tab[6]  = 1'b1;
        run_prog(30, 7, 12'd30, "R6/R10 bypass taken", -1, 1'b1);
        // R6: no compare anywhere, predicted-taken bit ignored, flag 0 falls through
        clear_prog();
        mem[3] = enc(2'd3, 1'b1, 12'd20);
        run_prog(20, 3, 12'd4, "R6 bypass fall-through", -1, 1'b1);
        // random programs
        for (int p = 0; p < 8; p++) begin
            for (int k = 0; k < 64; k++) begin
                mem[k] = enc(2'($urandom % 4), 1'($urandom % 2), 12'($urandom % 64));
                tab[k] = 1'($urandom % 2);
            end
            run_prog(400, -1, 12'd0, "", -1, 1'b0);
        end
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule